// File: doc/BRIEF.md
# Hybrid Nonlinear/Linear Shift-Register Keystream Generator

This block produces a pseudo-random keystream one bit per clock from two coupled 80-bit shift registers. One register is nonlinear and one is linear. A nonlinear combining function reads taps from both registers. That function, together with a handful of linear taps from the nonlinear register, gives the output bit.

A one-cycle `start` pulse loads a secret key and an IV. The block then mixes the state for 160 rounds. During those rounds the output bit is folded back into both feedback paths, and a divide-by-4 enable lets the state move only on every fourth clock. After the last round the feedback of the output bit is cut. `ks_valid` rises, and the block advances once per accepted keystream bit (`ks_valid && ks_ready`). It can do so on every cycle.

Inside the block, the nonlinear register is built in Galois form. Its higher-order feedback terms are injected at stages 59, 64 and 69 rather than all at the top. This form emits exactly the same bit sequence as the end-fed form. A term is held off until the steps taken since load reach that term's injection depth.

Top module: `hybrid_keystream_gen`

## Requirements
- R1: After reset `ks_valid` is low, and it stays low until a `start` pulse is taken.
- R2: `ks_valid` rises exactly 640 clock cycles after the edge that samples `start`. That is 160 initialization rounds, each taking 4 clocks.
- R3: The accepted keystream equals an end-fed reference model, bit for bit. Each reference step shifts both registers toward index 0 and does the following:
  - Output: z = n1^n2^n4^n10^n31^n43^n56^h.
  - Combining term: h = a&b ^ c&e ^ a&d&e ^ b&c&d ^ d, with a=l3, b=l25, c=l46, d=l64, e=n50.
  - Linear feedback into l79: l0^l13^l23^l38^l51^l62.
  - Nonlinear feedback into n79: l0^n0^n13^(n60&n52^n45)^(n63&n60&n37^n28&n21)^(n52&n45&n37&n33^n21&n17).
  - During the 160 initialization rounds, z is added to both feedback values.
  - `ks_bit` is z of the current state.
- R4: While `ks_valid` is high and `ks_ready` is low, `ks_bit` holds its value and no bit is lost. `ks_valid` stays high until the next `start`.
- R5: A `start` taken while streaming drops `ks_valid` in the next cycle. It reloads the key and IV and restarts initialization, so the same key and IV repeat the same keystream from its first bit.
- R6: A `start` taken during initialization restarts it. The 640-cycle count begins again from the new `start`.
- R7: Load places the key in the nonlinear register, with key bit i going to n_i. IV bit i goes to l_i for i < 64, and l64..l79 are set to one. The linear register is therefore never all zero, and an all-zero key and IV still follow R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load key and IV and begin initialization |
| key | input | 80 | Secret key |
| iv | input | 64 | Initialization vector |
| ks_ready | input | 1 | Consumer accepts the current keystream bit |
| ks_valid | output | 1 | Keystream bit is valid |
| ks_bit | output | 1 | Keystream bit |

## Verification
The assertions assume the following about the inputs:
- `start` is a pulse sampled on a clock edge.
- `key` and `iv` are stable in the cycle `start` is high.
- `ks_ready` may change freely, with no requirement to stay high once raised.

The stimulus keeps within these limits. It drives every input just after a rising edge and always raises `start` with `ks_ready` low. It then holds `start` for exactly one edge. This keeps each abort free of a concurrent handshake. Because of that, the expected-bit queue can be flushed at the same moment the pulse is driven.

// File: rtl/hks_pkg.sv
// Shared types and tap functions for the hybrid keystream generator.
// Assumes 80-bit registers; tap positions below are fixed for that length.
package hks_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_INIT   = 2'd1,
        PH_STREAM = 2'd2
    } phase_e;

    // Galois injection depths of the three nonlinear feedback groups
    localparam int GD_A = 20;
    localparam int GD_B = 10;
    localparam int GD_C = 15;

    // Five-input nonlinear combining function
    function automatic logic mix5(input logic a, input logic b, input logic c,
                                  input logic d, input logic e);
        return (a & b) ^ (c & e) ^ (a & d & e) ^ (b & c & d) ^ d;
    endfunction

endpackage

// File: rtl/hks_ctrl.sv
// Phase sequencer: handles start/abort, the divide-by-N init enable,
// the round counter and the keystream handshake.
// Assumes start is a single-edge pulse; start has priority over any step.
module hks_ctrl #(
    parameter int ROUNDS = 160,
    parameter int DIV    = 4,
    localparam int CW    = $clog2(ROUNDS + 1),
    localparam int DW    = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ks_ready,
    output logic          load,
    output logic          step,
    output logic          init_mode,
    output logic          warm,
    output logic [CW-1:0] steps_done,
    output logic          ks_valid
);
    import hks_pkg::*;

    localparam logic [DW-1:0] DIV_LAST   = DW'(DIV - 1);
    localparam logic [CW-1:0] ROUND_LAST = CW'(ROUNDS - 1);

    phase_e        phase_q;
    logic [DW-1:0] div_q;
    logic [CW-1:0] rounds_q;
    logic          div_tick;

    // Divided enable: true on the last phase of each init slot
    always_comb div_tick = (div_q == DIV_LAST);

    // Step decision: throttled in init, handshake-paced in stream
    always_comb begin
        step = 1'b0;
        if (!start) begin
            if (phase_q == PH_INIT)        step = div_tick;
            else if (phase_q == PH_STREAM) step = ks_ready;
        end
    end

    // Phase, divider and round counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            div_q    <= '0;
            rounds_q <= '0;
        end else if (start) begin
            phase_q  <= PH_INIT;
            div_q    <= '0;
            rounds_q <= '0;
        end else if (phase_q == PH_INIT) begin
            if (div_tick) begin
                div_q    <= '0;
                rounds_q <= rounds_q + 1'b1;
                if (rounds_q == ROUND_LAST) phase_q <= PH_STREAM;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign load       = start;
    assign init_mode  = (phase_q == PH_INIT);
    assign warm       = (phase_q == PH_STREAM);
    assign steps_done = rounds_q;
    assign ks_valid   = (phase_q == PH_STREAM);

endmodule

// File: rtl/hks_lfsr.sv
// Linear register: loads IV into the low bits with ones above, then
// shifts toward bit 0 feeding tap XOR (plus optional output feedback) in at the top.
// Assumes IV_W < LEN so at least one bit is forced to one.
module hks_lfsr #(
    parameter int LEN  = 80,
    parameter int IV_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [IV_W-1:0] iv,
    input  logic            fb_extra,
    output logic [LEN-1:0]  state
);
    logic [LEN-1:0] state_q;
    logic [LEN-1:0] load_val;
    logic           lin_fb;

    // Load image: IV low, ones high
    generate
        if (IV_W < LEN) begin : g_pad
            assign load_val = {{(LEN - IV_W){1'b1}}, iv};
        end else begin : g_nopad
            assign load_val = iv[LEN-1:0];
        end
    endgenerate

    // Primitive-polynomial tap XOR
    always_comb lin_fb = state_q[0] ^ state_q[13] ^ state_q[23] ^ state_q[38]
                       ^ state_q[51] ^ state_q[62] ^ fb_extra;

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= '0;
        else if (load)   state_q <= load_val;
        else if (step)   state_q <= {lin_fb, state_q[LEN-1:1]};
    end

    assign state = state_q;

endmodule

// File: rtl/hks_nfsr_galois.sv
// Nonlinear register in Galois form: the top stage takes the linear part,
// and three nonlinear groups are injected at stages LEN-1-depth, evaluated on
// bits shifted down by that depth. A group is suppressed until 'depth' steps
// have elapsed since load, so the sequence equals the end-fed form.
// Assumes LEN = 80 and all read taps lie below the lowest injection stage.
module hks_nfsr_galois #(
    parameter int LEN = 80,
    parameter int CW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [LEN-1:0] key,
    input  logic           lin_bit,
    input  logic           fb_extra,
    input  logic [CW-1:0]  steps_done,
    input  logic           warm,
    output logic [LEN-1:0] state
);
    import hks_pkg::*;

    localparam int POS_A = LEN - 1 - GD_A;
    localparam int POS_B = LEN - 1 - GD_B;
    localparam int POS_C = LEN - 1 - GD_C;
    localparam logic [CW-1:0] DA = CW'(GD_A);
    localparam logic [CW-1:0] DB = CW'(GD_B);
    localparam logic [CW-1:0] DC = CW'(GD_C);

    logic [LEN-1:0] q;
    logic [LEN-1:0] inject;
    logic [LEN-1:0] nxt;
    logic           live_a, live_b, live_c;
    logic           term_a, term_b, term_c;

    // Group enables: a group may act only once its source step exists
    always_comb begin
        live_a = warm || (steps_done >= DA);
        live_b = warm || (steps_done >= DB);
        live_c = warm || (steps_done >= DC);
    end

    // Nonlinear groups read on taps shifted down by their depth
    always_comb begin
        term_a = (q[40] & q[32]) ^ q[25];
        term_b = (q[53] & q[50] & q[27]) ^ (q[18] & q[11]);
        term_c = (q[37] & q[30] & q[22] & q[18]) ^ (q[6] & q[2]);
    end

    // Injection vector across stages
    always_comb begin
        inject        = '0;
        inject[POS_A] = term_a & live_a;
        inject[POS_B] = term_b & live_b;
        inject[POS_C] = term_c & live_c;
    end

    // Next state: plain shift plus injections; top stage takes linear part
    generate
        for (genvar i = 0; i < LEN - 1; i++) begin : g_stage
            assign nxt[i] = q[i+1] ^ inject[i];
        end
    endgenerate
    assign nxt[LEN-1] = lin_bit ^ q[0] ^ q[13] ^ fb_extra;

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= key;
        else if (step)  q <= nxt;
    end

    assign state = q;

endmodule

// File: rtl/hks_combiner.sv
// Output function: linear taps of the nonlinear register XOR a five-input
// nonlinear mix of linear-register taps and one nonlinear tap.
// Assumes every nonlinear tap lies below the Galois injection stages.
module hks_combiner #(
    parameter int NLEN = 80,
    parameter int LLEN = 80
) (
    input  logic [NLEN-1:0] nstate,
    input  logic [LLEN-1:0] lstate,
    output logic            z
);
    import hks_pkg::*;

    // Combined output bit
    always_comb z = nstate[1] ^ nstate[2] ^ nstate[4] ^ nstate[10] ^ nstate[31]
                  ^ nstate[43] ^ nstate[56]
                  ^ mix5(lstate[3], lstate[25], lstate[46], lstate[64], nstate[50]);

endmodule

// File: rtl/hybrid_keystream_gen.sv
// Top level: sequencer, linear register, Galois nonlinear register and
// output combiner. Output feedback is gated by the init phase.
// Assumes default lengths (taps are fixed for 80-bit registers).
module hybrid_keystream_gen #(
    parameter int NLEN      = 80,
    parameter int LLEN      = 80,
    parameter int IV_W      = 64,
    parameter int DIV_RATIO = 4,
    localparam int INIT_ROUNDS = 2 * NLEN,
    localparam int CW          = $clog2(INIT_ROUNDS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NLEN-1:0] key,
    input  logic [IV_W-1:0] iv,
    input  logic            ks_ready,
    output logic            ks_valid,
    output logic            ks_bit
);
    logic            load, step, init_mode, warm;
    logic [CW-1:0]   steps_done;
    logic [LLEN-1:0] lfsr_q;
    logic [NLEN-1:0] nfsr_q;
    logic            z;
    logic            zfb;

    hks_ctrl #(.ROUNDS(INIT_ROUNDS), .DIV(DIV_RATIO)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ks_ready(ks_ready),
        .load(load), .step(step), .init_mode(init_mode), .warm(warm),
        .steps_done(steps_done), .ks_valid(ks_valid)
    );

    // Output feedback only while initializing
    always_comb zfb = z & init_mode;

    hks_lfsr #(.LEN(LLEN), .IV_W(IV_W)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .iv(iv),
        .fb_extra(zfb), .state(lfsr_q)
    );

    hks_nfsr_galois #(.LEN(NLEN), .CW(CW)) nfsr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .key(key),
        .lin_bit(lfsr_q[0]), .fb_extra(zfb), .steps_done(steps_done),
        .warm(warm), .state(nfsr_q)
    );

    hks_combiner #(.NLEN(NLEN), .LLEN(LLEN)) comb_i (
        .nstate(nfsr_q), .lstate(lfsr_q), .z(z)
    );

    assign ks_bit = z;

endmodule

// File: rtl/hks_chk.sv
// Protocol checker bound to the top: latency, hold, abort and state sanity.
// Assumes start is sampled on clock edges and rst_n is synchronous.
module hks_chk #(
    parameter int ROUNDS = 160,
    parameter int DIV    = 4,
    parameter int LLEN   = 80,
    localparam int LAT   = ROUNDS * DIV,
    localparam int TW    = $clog2(LAT + 2) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            ks_ready,
    input logic            ks_valid,
    input logic            ks_bit,
    input logic [LLEN-1:0] lin_state
);
    logic [TW-1:0] since_start;
    logic          started;

    // Cycles since the last start, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_start <= '0;
            started     <= 1'b0;
        end else if (start) begin
            since_start <= '0;
            started     <= 1'b1;
        end else if (since_start != {TW{1'b1}}) begin
            since_start <= since_start + 1'b1;
        end
    end

    // R1
    valid_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> started);

    // R2
    init_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_valid) |-> (since_start == TW'(LAT)));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && !ks_ready && !start) |=> $stable(ks_bit));

    // R4
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && !start) |=> ks_valid);

    // R5
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ks_valid);

    // R7
    lin_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (lin_state != '0));

endmodule

bind hybrid_keystream_gen hks_chk #(
    .ROUNDS(INIT_ROUNDS), .DIV(DIV_RATIO), .LLEN(LLEN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ks_ready(ks_ready),
    .ks_valid(ks_valid), .ks_bit(ks_bit), .lin_state(lfsr_q)
);

// File: tb/hybrid_keystream_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks compute the end-fed reference and queue
// expected bits; a negedge monitor pops and compares on each handshake.
module hybrid_keystream_gen_tb_top;
    import hks_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] key = '0;
    logic [63:0] iv = '0;
    logic        ks_ready = 1'b0;
    logic        ks_valid;
    logic        ks_bit;

    int checks = 0;
    int fails  = 0;
    bit exp_q[$];
    logic [79:0] rn, rl;
    bit   prev_stall = 0;
    bit   prev_bit   = 0;

    always #2.5 clk = ~clk;

    hybrid_keystream_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
        .ks_ready(ks_ready), .ks_valid(ks_valid), .ks_bit(ks_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: end-fed output bit
    function automatic bit ref_z(input logic [79:0] n, input logic [79:0] l);
        return n[1]^n[2]^n[4]^n[10]^n[31]^n[43]^n[56]
             ^ mix5(l[3], l[25], l[46], l[64], n[50]);
    endfunction

    // Reference: one end-fed step of both registers
    task automatic ref_step(input bit init);
        bit z, lf, nf;
        z  = ref_z(rn, rl) & init;
        lf = rl[0]^rl[13]^rl[23]^rl[38]^rl[51]^rl[62]^z;
        nf = rl[0]^rn[0]^rn[13]^(rn[60]&rn[52]^rn[45])
           ^ (rn[63]&rn[60]&rn[37]^rn[28]&rn[21])
           ^ (rn[52]&rn[45]&rn[37]&rn[33]^rn[21]&rn[17]) ^ z;
        rl = {lf, rl[79:1]};
        rn = {nf, rn[79:1]};
    endtask

    // Driver: queue expected bits then pulse start (ready low)
    task automatic start_session(input logic [79:0] k, input logic [63:0] v, input int nbits);
        rn = k;
        rl = {16'hFFFF, v};
        for (int i = 0; i < 160; i++) ref_step(1'b1);
        @(posedge clk); #1;
        ks_ready = 1'b0;
        exp_q.delete();
        for (int i = 0; i < nbits; i++) begin
            exp_q.push_back(ref_z(rn, rl));
            ref_step(1'b0);
        end
        key = k; iv = v; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // Count cycles with valid low after the start edge
    task automatic wait_valid(input string req);
        int cnt = 0;
        while (1) begin
            @(negedge clk);
            if (ks_valid) break;
            cnt++;
        end
        check(cnt == 640, req, cnt, 640);
    endtask

    // Consume bits until only 'left' remain queued
    task automatic drain(input bit stall, input int left);
        int k = 0;
        while (exp_q.size() > left) begin
            ks_ready = stall ? ((k % 3) != 2) : 1'b1;
            k++;
            @(posedge clk); #1;
        end
        ks_ready = 1'b0;
        check(exp_q.size() == left, "R3", exp_q.size(), left);
    endtask

    // Monitor: compare on handshakes, check holds during stalls
    always @(negedge clk) begin
        if (rst_n && ks_valid) begin
            if (prev_stall) check(ks_bit == prev_bit, "R4", ks_bit, prev_bit);
            if (ks_ready) begin
                if (exp_q.size() == 0) check(1'b0, "R3 unexpected bit", ks_bit, 0);
                else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(ks_bit == e, "R3", ks_bit, e);
                end
            end
            prev_stall = !ks_ready;
            prev_bit   = ks_bit;
        end else begin
            prev_stall = 0;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [79:0] k;
        logic [63:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: no valid without start
        begin
            int hi = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (ks_valid) hi++;
            end
            check(hi == 0, "R1", hi, 0);
        end
        // R2/R3: random keys and IVs
        for (int s = 0; s < 3; s++) begin
            k = {$urandom(), $urandom(), $urandom()};
            v = {$urandom(), $urandom()};
            start_session(k, v, 256);
            wait_valid("R2");
            drain(1'b0, 0);
        end
        // R4: stalling consumer
        k = {$urandom(), $urandom(), $urandom()};
        v = {$urandom(), $urandom()};
        start_session(k, v, 200);
        wait_valid("R2");
        drain(1'b1, 0);
        repeat (5) @(negedge clk);
        check(ks_valid == 1'b1, "R4 valid held", ks_valid, 1);
        // R7: all-zero and all-one key/IV
        start_session('0, '0, 200);
        wait_valid("R2");
        drain(1'b0, 0);
        start_session('1, '1, 200);
        wait_valid("R2");
        drain(1'b0, 0);
        // R5: abort mid-stream, same key restarts same sequence
        k = {$urandom(), $urandom(), $urandom()};
        v = {$urandom(), $urandom()};
        start_session(k, v, 200);
        wait_valid("R2");
        drain(1'b0, 120);
        start_session(k, v, 200);
        @(negedge clk);
        check(ks_valid == 1'b0, "R5 valid drop", ks_valid, 0);
        begin
            int cnt = 1;
            while (1) begin
                @(negedge clk);
                if (ks_valid) break;
                cnt++;
            end
            check(cnt == 640, "R5", cnt, 640);
        end
        drain(1'b1, 0);
        // R6: restart during initialization
        start_session(k ^ 80'h1, v, 50);
        repeat (200) @(posedge clk);
        #1;
        k = {$urandom(), $urandom(), $urandom()};
        v = {$urandom(), $urandom()};
        start_session(k, v, 200);
        wait_valid("R6");
        drain(1'b0, 0);
        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule